// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block buffers audio samples between a bus or DMA side and a serial audio engine. It holds one transmit FIFO, filled by the bus and drained one sample per serializer slot, and one receive FIFO, filled by the serializer and drained by the bus. Each FIFO compares its fill level against a programmable threshold. The result drives a burst service request toward a DMA engine and an optional interrupt source. The DMA engine moves data in bursts of 16 samples through one data address that serves both directions.

Either FIFO can be emptied on its own by a flush strobe. A mode setting ties the two together so that the transmit flush empties both. Sticky underrun and overrun flags record slots with nothing to send and samples with no room to land. When the transmit FIFO runs dry, a play-last option repeats the most recent sample instead of sending silence. A synchronous soft reset returns the storage, the flags and all configuration to their defaults.

Top module: `audio_sample_fifo`

## Requirements
- R1: After `rstN` is released, both levels are 0, `txSample` is 0, both DMA requests are 0 and `irq` is 0. The thresholds default to 8 for transmit and 7 for receive.
- R2: The transmit FIFO returns samples in write order and holds at most 32 entries. A write arriving while it holds 32 entries is discarded. `txLevel` changes on the edge that samples the write.
- R3: `txDmaReq` is 1 exactly when transmit DMA is enabled and `txLevel` is less than or equal to the transmit threshold.
- R4: `rxDmaReq` is 1 exactly when receive DMA is enabled and `rxLevel` is greater than or equal to the receive threshold.
- R5: The receive FIFO returns samples in arrival order on `rxRdData`, which shows the oldest entry before it is read. It holds at most 32 entries. A sample pushed while it is full is discarded and sets the sticky overrun flag. A read while it is empty is ignored.
- R6: A slot request while the transmit FIFO is empty sets the sticky underrun flag. With play-last off, `txSample` becomes 0.
- R7: With play-last on, a slot request on an empty transmit FIFO makes `txSample` repeat the last sample that was taken from the FIFO.
- R8: With shared mode off, `txFlush` empties only the transmit FIFO and clears the underrun flag. `rxFlush` empties only the receive FIFO and clears the overrun flag. Both take effect on the edge that samples them.
- R9: With shared mode on, `txFlush` empties both FIFOs and clears both flags, and `rxFlush` has no effect.
- R10: `irq` is the OR of the enabled sources. Bit 0 of `modeIntEn` enables transmit-threshold (the R3 condition without the DMA enable), bit 1 enables receive-threshold (the R4 condition without the DMA enable), bit 2 enables underrun and bit 3 enables overrun.
- R11: `softReset` empties both FIFOs, clears both flags, zeroes `txSample` and the held last sample, restores the thresholds to 8 and 7, and clears all mode settings. It takes priority over any configuration write in the same cycle.
- R12: On the edge that samples `txSlotReq` with a non-empty transmit FIFO, `txSample` takes the oldest entry and the level drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Synchronous return to defaults |
| thrWe | input | 1 | Load both thresholds |
| thrTxIn | input | THR_W | Transmit threshold value |
| thrRxIn | input | THR_W | Receive threshold value |
| modeWe | input | 1 | Load the mode fields |
| modeTxDmaEn | input | 1 | Enable the transmit DMA request |
| modeRxDmaEn | input | 1 | Enable the receive DMA request |
| modeIntEn | input | 4 | Interrupt source enables (see R10) |
| modeShared | input | 1 | Shared flush mode |
| modePlayLast | input | 1 | Repeat the last sample on underrun |
| txFlush | input | 1 | Flush strobe for transmit (both FIFOs in shared mode) |
| rxFlush | input | 1 | Flush strobe for receive |
| txWrValid | input | 1 | Bus writes a transmit sample |
| txWrData | input | DATA_W | Transmit sample from the bus |
| txSlotReq | input | 1 | Serializer takes one sample |
| txSample | output | DATA_W | Sample handed to the serializer |
| rxPushValid | input | 1 | Serializer delivers a receive sample |
| rxPushData | input | DATA_W | Received sample |
| rxRdReq | input | 1 | Bus reads one receive sample |
| rxRdData | output | DATA_W | Oldest receive sample |
| txLevel | output | LVL_W | Transmit fill level |
| rxLevel | output | LVL_W | Receive fill level |
| txDmaReq | output | 1 | Transmit burst request |
| rxDmaReq | output | 1 | Receive burst request |
| irq | output | 1 | Interrupt |

## Verification
The bench pushes the transmit FIFO past 32 entries and drains it. A design that wrapped its write pointer would overwrite the oldest sample, and the scoreboard would then see the order break. It sweeps both levels across the default thresholds. A design that used a strict comparison would drop `txDmaReq` at level 8 or hold off `rxDmaReq` until level 8. It drains the transmit FIFO into underrun with play-last off and then on, which catches a design that sends stale data instead of zeros or zeros instead of the held sample. It also exercises both flush modes. A design that ignored shared mode would leave receive data behind after the transmit flush, and one that still honoured `rxFlush` in shared mode would empty the receive FIFO when it should not.

// File: rtl/asf_pkg.sv
`timescale 1ns/1ps
package asf_pkg;
  // One-cycle actions the control hands to the datapath.
  typedef struct packed {
    logic flushTx;   // empty transmit storage
    logic flushRx;   // empty receive storage
    logic pushTx;    // accepted bus write
    logic popTx;     // slot served from storage
    logic fillTx;    // slot with empty storage
    logic pushRx;    // accepted serializer sample
    logic popRx;     // accepted bus read
    logic clearOut;  // zero the output and held sample
  } asf_strobes_t;
endpackage

// File: rtl/asf_ring.sv
`timescale 1ns/1ps
module asf_ring #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      unique case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> level != FULL_LVL);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> level != '0);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> level == '0);
endmodule

// File: rtl/asf_datapath.sv
`timescale 1ns/1ps
module asf_datapath
  import asf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  asf_strobes_t      strb,
  input  logic              playLast,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] txSample,
  output logic [DATA_W-1:0] rxRdData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  logic [DATA_W-1:0] txHead;
  logic [DATA_W-1:0] lastSample;

  asf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txRing (
    .clk(clk), .rstN(rstN), .clr(strb.flushTx), .push(strb.pushTx),
    .pop(strb.popTx), .wrData(txWrData), .headData(txHead), .level(txLevel));

  asf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxRing (
    .clk(clk), .rstN(rstN), .clr(strb.flushRx), .push(strb.pushRx),
    .pop(strb.popRx), .wrData(rxPushData), .headData(rxRdData), .level(rxLevel));

  // Output register toward the serializer and the sample it may repeat.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSample   <= '0;
      lastSample <= '0;
    end else if (strb.clearOut) begin
      txSample   <= '0;
      lastSample <= '0;
    end else if (strb.popTx) begin
      txSample   <= txHead;
      lastSample <= txHead;
    end else if (strb.fillTx) begin
      txSample   <= playLast ? lastSample : '0;
    end
  end

  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillTx && !playLast) |=> txSample == '0);
  a_r7_repeat_last: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillTx && playLast && !strb.clearOut) |=> $stable(lastSample) && txSample == lastSample);
endmodule

// File: rtl/asf_ctrl.sv
`timescale 1ns/1ps
module asf_ctrl
  import asf_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int THR_W      = 5,
  parameter int TX_THR_RST = 8,
  parameter int RX_THR_RST = 7,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic             thrWe,
  input  logic [THR_W-1:0] thrTxIn,
  input  logic [THR_W-1:0] thrRxIn,
  input  logic             modeWe,
  input  logic             modeTxDmaEn,
  input  logic             modeRxDmaEn,
  input  logic [3:0]       modeIntEn,
  input  logic             modeShared,
  input  logic             modePlayLast,
  input  logic             txFlush,
  input  logic             rxFlush,
  input  logic             txWrValid,
  input  logic             txSlotReq,
  input  logic             rxPushValid,
  input  logic             rxRdReq,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output asf_strobes_t     strb,
  output logic             playLast,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL   = LVL_W'(DEPTH);
  localparam logic [THR_W-1:0] TX_THR_DEF = THR_W'(TX_THR_RST);
  localparam logic [THR_W-1:0] RX_THR_DEF = THR_W'(RX_THR_RST);

  logic [THR_W-1:0] txThr, rxThr;
  logic             txDmaEn, rxDmaEn, sharedMode;
  logic [3:0]       intEn;
  logic             underrunFlag, overrunFlag;
  logic             txEmpty, txFull, rxEmpty, rxFull;
  logic             txBelow, rxAbove;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || softReset) begin
      txThr      <= TX_THR_DEF;
      rxThr      <= RX_THR_DEF;
      txDmaEn    <= 1'b0;
      rxDmaEn    <= 1'b0;
      intEn      <= '0;
      sharedMode <= 1'b0;
      playLast   <= 1'b0;
    end else begin
      if (thrWe) begin
        txThr <= thrTxIn;
        rxThr <= thrRxIn;
      end
      if (modeWe) begin
        txDmaEn    <= modeTxDmaEn;
        rxDmaEn    <= modeRxDmaEn;
        intEn      <= modeIntEn;
        sharedMode <= modeShared;
        playLast   <= modePlayLast;
      end
    end
  end

  assign txEmpty = (txLevel == '0);
  assign txFull  = (txLevel == FULL_LVL);
  assign rxEmpty = (rxLevel == '0);
  assign rxFull  = (rxLevel == FULL_LVL);

  always_comb begin
    strb          = '0;
    strb.clearOut = softReset;
    strb.flushTx  = softReset | txFlush;
    strb.flushRx  = softReset | (sharedMode ? txFlush : rxFlush);
    strb.pushTx   = txWrValid & ~txFull & ~strb.flushTx;
    strb.popTx    = txSlotReq & ~txEmpty & ~strb.flushTx;
    strb.fillTx   = txSlotReq & txEmpty;
    strb.pushRx   = rxPushValid & ~rxFull & ~strb.flushRx;
    strb.popRx    = rxRdReq & ~rxEmpty & ~strb.flushRx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrunFlag <= 1'b0;
      overrunFlag  <= 1'b0;
    end else begin
      if (strb.flushTx)     underrunFlag <= 1'b0;
      else if (strb.fillTx) underrunFlag <= 1'b1;
      if (strb.flushRx)                 overrunFlag <= 1'b0;
      else if (rxPushValid && rxFull)   overrunFlag <= 1'b1;
    end
  end

  assign txBelow  = (txLevel <= LVL_W'(txThr));
  assign rxAbove  = (rxLevel >= LVL_W'(rxThr));
  assign txDmaReq = txDmaEn & txBelow;
  assign rxDmaReq = rxDmaEn & rxAbove;
  assign irq      = |(intEn & {overrunFlag, underrunFlag, rxAbove, txBelow});

  a_r6_underrun_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrunFlag) |-> $past(txSlotReq && txLevel == '0));
  a_r9_shared_flush: assert property (@(posedge clk) disable iff (!rstN)
    (sharedMode && txFlush) |=> rxLevel == '0);
  a_r8_rx_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (!sharedMode && txFlush && !rxFlush && !softReset && !rxPushValid && !rxRdReq)
      |=> $stable(rxLevel));
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> txLevel == '0 && rxLevel == '0 && !underrunFlag && !overrunFlag);
endmodule

// File: rtl/audio_sample_fifo.sv
`timescale 1ns/1ps
module audio_sample_fifo
  import asf_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int DEPTH      = 32,
  parameter int THR_W      = 5,
  parameter int TX_THR_RST = 8,
  parameter int RX_THR_RST = 7,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              thrWe,
  input  logic [THR_W-1:0]  thrTxIn,
  input  logic [THR_W-1:0]  thrRxIn,
  input  logic              modeWe,
  input  logic              modeTxDmaEn,
  input  logic              modeRxDmaEn,
  input  logic [3:0]        modeIntEn,
  input  logic              modeShared,
  input  logic              modePlayLast,
  input  logic              txFlush,
  input  logic              rxFlush,
  input  logic              txWrValid,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txSlotReq,
  output logic [DATA_W-1:0] txSample,
  input  logic              rxPushValid,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxRdReq,
  output logic [DATA_W-1:0] rxRdData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              irq
);
  asf_strobes_t strb;
  logic         playLast;

  asf_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .TX_THR_RST(TX_THR_RST),
             .RX_THR_RST(RX_THR_RST)) ctrl (
    .clk(clk), .rstN(rstN), .softReset(softReset),
    .thrWe(thrWe), .thrTxIn(thrTxIn), .thrRxIn(thrRxIn),
    .modeWe(modeWe), .modeTxDmaEn(modeTxDmaEn), .modeRxDmaEn(modeRxDmaEn),
    .modeIntEn(modeIntEn), .modeShared(modeShared), .modePlayLast(modePlayLast),
    .txFlush(txFlush), .rxFlush(rxFlush), .txWrValid(txWrValid),
    .txSlotReq(txSlotReq), .rxPushValid(rxPushValid), .rxRdReq(rxRdReq),
    .txLevel(txLevel), .rxLevel(rxLevel), .strb(strb), .playLast(playLast),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq));

  asf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .playLast(playLast),
    .txWrData(txWrData), .rxPushData(rxPushData), .txSample(txSample),
    .rxRdData(rxRdData), .txLevel(txLevel), .rxLevel(rxLevel));
endmodule

// File: tb/audio_sample_fifo_test.sv
`timescale 1ns/1ps
module audio_sample_fifo_test;
  localparam int DW = 24;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softReset = 0, thrWe = 0, modeWe = 0;
  logic [4:0] thrTxIn = 0, thrRxIn = 0;
  logic modeTxDmaEn = 0, modeRxDmaEn = 0, modeShared = 0, modePlayLast = 0;
  logic [3:0] modeIntEn = 0;
  logic txFlush = 0, rxFlush = 0, txWrValid = 0, txSlotReq = 0;
  logic rxPushValid = 0, rxRdReq = 0;
  logic [DW-1:0] txWrData = 0, rxPushData = 0;
  logic [DW-1:0] txSample, rxRdData;
  logic [5:0] txLevel, rxLevel;
  logic txDmaReq, rxDmaReq, irq;

  always #2.5 clk = ~clk;

  audio_sample_fifo uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  // reference model
  logic [DW-1:0] txQ[$], rxQ[$], outQ[$];
  int mTxThr = 8, mRxThr = 7;
  bit mTxEn = 0, mRxEn = 0, mShared = 0, mPlay = 0, mUnf = 0, mOvf = 0;
  logic [3:0] mIe = 0;
  logic [DW-1:0] mLast = 0;
  int slotsIssued = 0, slotsChecked = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(string req);
    bit eIrq;
    eIrq = (mIe[0] && txQ.size() <= mTxThr) || (mIe[1] && rxQ.size() >= mRxThr) ||
           (mIe[2] && mUnf) || (mIe[3] && mOvf);
    chk(req, "txLevel", int'(txLevel), txQ.size());
    chk(req, "rxLevel", int'(rxLevel), rxQ.size());
    chk(req, "txDmaReq", int'(txDmaReq), int'(mTxEn && txQ.size() <= mTxThr));
    chk(req, "rxDmaReq", int'(rxDmaReq), int'(mRxEn && rxQ.size() >= mRxThr));
    chk(req, "irq", int'(irq), int'(eIrq));
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor for the serializer side
  initial begin
    forever begin
      @(negedge clk);
      while (slotsChecked < slotsIssued) begin
        logic [DW-1:0] e;
        e = outQ.pop_front();
        slotsChecked++;
        chk("R12", "txSample", int'(txSample), int'(e));
      end
    end
  end

  task automatic txWrite(logic [DW-1:0] d);
    txWrValid = 1; txWrData = d; tick(); txWrValid = 0;
    if (txQ.size() < DEPTH) txQ.push_back(d);
  endtask

  task automatic txSlot();
    txSlotReq = 1; tick(); txSlotReq = 0;
    if (txQ.size() > 0) begin
      mLast = txQ.pop_front(); outQ.push_back(mLast);
    end else begin
      outQ.push_back(mPlay ? mLast : '0); mUnf = 1;
    end
    slotsIssued++;
  endtask

  task automatic rxPush(logic [DW-1:0] d);
    rxPushValid = 1; rxPushData = d; tick(); rxPushValid = 0;
    if (rxQ.size() < DEPTH) rxQ.push_back(d); else mOvf = 1;
  endtask

  task automatic rxRead();
    if (rxQ.size() > 0) chk("R5", "rxRdData", int'(rxRdData), int'(rxQ[0]));
    rxRdReq = 1; tick(); rxRdReq = 0;
    if (rxQ.size() > 0) void'(rxQ.pop_front());
  endtask

  task automatic setMode(bit te, bit re, logic [3:0] ie, bit sh, bit pl);
    modeWe = 1; modeTxDmaEn = te; modeRxDmaEn = re; modeIntEn = ie;
    modeShared = sh; modePlayLast = pl; tick(); modeWe = 0;
    mTxEn = te; mRxEn = re; mIe = ie; mShared = sh; mPlay = pl;
  endtask

  task automatic doTxFlush();
    txFlush = 1; tick(); txFlush = 0;
    txQ.delete(); mUnf = 0;
    if (mShared) begin rxQ.delete(); mOvf = 0; end
  endtask

  task automatic doRxFlush();
    rxFlush = 1; tick(); rxFlush = 0;
    if (!mShared) begin rxQ.delete(); mOvf = 0; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // R1: reset state
    checkState("R1");
    chk("R1", "txSample", int'(txSample), 0);

    // R1 R3 R4: default thresholds seen through the requests
    setMode(1, 1, 4'b0000, 0, 0);
    checkState("R1");

    // R3: sweep transmit level across threshold 8
    for (int i = 0; i < 9; i++) begin
      txWrite(24'h100 + 24'(i));
      checkState("R3");
    end
    // R12 R2: ordered output
    for (int i = 0; i < 3; i++) txSlot();
    checkState("R2");

    // R2: fill past 32, overflow write is dropped
    for (int i = 0; i < 27; i++) txWrite(24'h200 + 24'(i));
    checkState("R2");
    for (int i = 0; i < 32; i++) txSlot();
    checkState("R2");

    // R6 R10: underrun, zero output
    setMode(1, 1, 4'b0100, 0, 0);
    checkState("R10");
    txSlot();
    #1 checkState("R6");
    chk("R6", "txSample", int'(txSample), 0);

    // R7: play-last repeats last sample
    setMode(1, 1, 4'b0000, 0, 1);
    txWrite(24'hABCDEF);
    txSlot();
    txSlot();
    txSlot();
    #1 chk("R7", "txSample", int'(txSample), 24'hABCDEF);

    // R4 R5: receive sweep and order
    for (int i = 0; i < 8; i++) begin
      rxPush(24'h300 + 24'(i));
      checkState("R4");
    end
    for (int i = 0; i < 8; i++) rxRead();
    checkState("R5");
    rxRead(); // read when empty is ignored
    checkState("R5");

    // R5 R10: overrun
    setMode(1, 1, 4'b1000, 0, 0);
    for (int i = 0; i < 33; i++) rxPush(24'h400 + 24'(i));
    checkState("R5");
    rxRead(); rxRead();
    checkState("R10");

    // R10: threshold interrupt sources
    setMode(0, 0, 4'b0011, 0, 0);
    checkState("R10");

    // R8: separate flushes
    setMode(1, 1, 4'b1100, 0, 0);
    txSlot(); // underrun again
    for (int i = 0; i < 5; i++) txWrite(24'h500 + 24'(i));
    checkState("R8");
    doTxFlush();
    checkState("R8");
    doRxFlush();
    checkState("R8");

    // R9: shared flush mode
    setMode(1, 1, 4'b1100, 1, 0);
    for (int i = 0; i < 4; i++) begin
      txWrite(24'h600 + 24'(i)); rxPush(24'h700 + 24'(i));
    end
    doRxFlush();
    checkState("R9");
    doTxFlush();
    checkState("R9");

    // R3 R4: programmed thresholds
    thrWe = 1; thrTxIn = 5'd2; thrRxIn = 5'd3; tick(); thrWe = 0;
    mTxThr = 2; mRxThr = 3;
    for (int i = 0; i < 3; i++) begin
      txWrite(24'h800 + 24'(i)); rxPush(24'h900 + 24'(i));
      checkState("R4");
    end
    txSlot();

    // R11: soft reset restores defaults, beats a same-cycle write
    softReset = 1; modeWe = 1; modeTxDmaEn = 1; modeIntEn = 4'hF;
    tick(); softReset = 0; modeWe = 0;
    txQ.delete(); rxQ.delete(); mTxThr = 8; mRxThr = 7; mTxEn = 0; mRxEn = 0;
    mIe = 0; mShared = 0; mPlay = 0; mUnf = 0; mOvf = 0; mLast = 0;
    checkState("R11");
    chk("R11", "txSample", int'(txSample), 0);
    setMode(1, 1, 4'b0000, 0, 1);
    for (int i = 0; i < 3; i++) txWrite(24'hA00 + 24'(i));
    checkState("R11");
    doTxFlush();
    txSlot(); // held sample was cleared: output 0
    tick();
    done = 1;
    summary();
    $finish;
  end
endmodule